// File: doc/BRIEF.md
# PWM Trigger Postscaler

This block sits between a PWM time base and an A/D converter. The time base emits a one-cycle special event pulse every time its compare matches, whether or not anything listens. The postscaler counts those pulses and forwards only one in every N+1 of them to the converter's start-of-conversion input. N is a 4-bit ratio field, so the division runs from 1:1 up to 1:16. This lets synchronized conversions run on every PWM period or on a slower cadence.

The occurrence counter returns to zero on reset. It also returns to zero whenever software writes the compare value register, which the block sees as a one-cycle strobe. This realigns the division phase after each reprogramming. Changing the ratio field alone keeps the count; the new ratio is used at the next comparison.

Control is a three-state machine, held in `pscl_fsm`:

- `PS_IDLE`: the count is zero and no trigger is issued.
- `PS_ACCUM`: one or more events have been counted, but not yet enough to fire.
- `PS_FIRE`: the one-cycle trigger is being driven.

Transitions:

- **clear**: the strobe is seen in any state; go to `PS_IDLE`.
- **count**: an event arrives and the count has not reached the ratio; go to `PS_ACCUM`.
- **match**: an event arrives and the count has reached the ratio; go to `PS_FIRE`.
- **settle**: no event arrives while in `PS_FIRE`; go to `PS_IDLE`.
- **hold**: no event arrives while in `PS_IDLE` or `PS_ACCUM`; stay in place.

Top module: `evt_postscaler`

## Requirements
- R1: After reset, `soc_trig` is 0 and the internal count is 0, so with ratio N the first trigger follows the (N+1)th event.
- R2: With ratio field N (0..15), exactly one trigger is issued for every N+1 raw events, on the event that brings the count to N. The count then wraps to 0.
- R3: `soc_trig` is high for one cycle, in the cycle right after the clock edge that samples the qualifying raw event, and at no other time.
- R4: With ratio field 0, every raw event yields a trigger one cycle later.
- R5: A `cmp_wr` strobe resets the count to 0, so the next trigger needs N+1 further events.
- R6: When `cmp_wr` and `raw_evt` are high in the same cycle, the clear wins: no trigger is issued and the count is 0.
- R7: Changing `div_sel` does not change the count. The new value is used at the next event comparison.
- R8: If the count is already at or above a newly programmed ratio, the next raw event issues a trigger and wraps the count to 0.
- R9: In cycles without a raw event or strobe, the count holds and no trigger is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_evt | input | 1 | One-cycle special event pulse from the PWM time base |
| div_sel | input | 4 | Ratio field N; forwards one event in N+1 |
| cmp_wr | input | 1 | Strobe marking a write to the compare value register |
| soc_trig | output | 1 | Divided one-cycle start-of-conversion trigger |

## Verification
The bench sweeps all sixteen ratios, both with events on every cycle and with sparse events. This catches an off-by-one in the match, which would fire on the Nth or (N+2)th event. It also catches a trigger that lasts two cycles at ratio 0. Strobes are placed partway through a count, and a strobe is made to coincide with the event that would otherwise fire. A design that let the event win, or failed to clear, would then trigger early. The ratio is raised and lowered mid-count, which exposes a design that clears on a ratio change or compares with equality only and so misses the wrap. A reset partway through a count shows whether the phase restarts.

// File: rtl/pwm_pscl_pkg.sv
package pwm_pscl_pkg;

    localparam int unsigned RATIO_W = 4;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_ACCUM = 2'd1,
        PS_FIRE  = 2'd2
    } ps_state_e;

endpackage

// File: rtl/pscl_count.sv
module pscl_count #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: a clear request leaves the count at zero
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R9: with no request the count holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/pscl_match.sv
module pscl_match #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ratio,
    output logic         hit
);

    // Greater-or-equal so a lowered ratio still wraps (R8)
    assign hit = (cnt >= ratio);

endmodule

// File: rtl/pscl_fsm.sv
module pscl_fsm
    import pwm_pscl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      evt,
    input  logic      wr,
    input  logic      hit,
    output logic      clr,
    output logic      inc,
    output logic      trig
);

    ps_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (wr) begin
            state_nx = PS_IDLE;
        end else if (evt) begin
            state_nx = hit ? PS_FIRE : PS_ACCUM;
        end else begin
            unique case (state)
                PS_IDLE:  state_nx = PS_IDLE;
                PS_ACCUM: state_nx = PS_ACCUM;
                PS_FIRE:  state_nx = PS_IDLE;
                default:  state_nx = PS_IDLE;
            endcase
        end
    end

    always_comb begin
        clr  = wr | (evt & hit);
        inc  = ~wr & evt & ~hit;
        trig = 1'b0;
        unique case (state)
            PS_IDLE:  trig = 1'b0;
            PS_ACCUM: trig = 1'b0;
            PS_FIRE:  trig = 1'b1;
            default:  trig = 1'b0;
        endcase
    end

    // R6: a strobe always suppresses the following trigger
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !trig);

    // R3: a trigger only ever follows a sampled event
    a_r3_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(evt));

endmodule

// File: rtl/evt_postscaler.sv
module evt_postscaler
    import pwm_pscl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raw_evt,
    input  logic [RATIO_W-1:0] div_sel,
    input  logic               cmp_wr,
    output logic               soc_trig
);

    logic [RATIO_W-1:0] cnt;
    logic               hit;
    logic               clr;
    logic               inc;

    pscl_count #(.W(RATIO_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (inc),
        .cnt   (cnt)
    );

    pscl_match #(.W(RATIO_W)) u_match (
        .cnt   (cnt),
        .ratio (div_sel),
        .hit   (hit)
    );

    pscl_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (raw_evt),
        .wr    (cmp_wr),
        .hit   (hit),
        .clr   (clr),
        .inc   (inc),
        .trig  (soc_trig)
    );

    // R4: ratio zero forwards every event
    a_r4_every_event: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == '0 && raw_evt && !cmp_wr) |=> soc_trig);

    // R2: the count has wrapped whenever a trigger is out
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        soc_trig |-> (cnt == '0));

endmodule

// File: tb/tb_evt_postscaler.sv
module tb_evt_postscaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_evt = 1'b0;
    logic [3:0] div_sel = 4'd0;
    logic       cmp_wr = 1'b0;
    logic       soc_trig;

    int total = 0;
    int bad = 0;
    int mcnt = 0;

    always #4 clk = ~clk;

    evt_postscaler dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_evt  (raw_evt),
        .div_sel  (div_sel),
        .cmp_wr   (cmp_wr),
        .soc_trig (soc_trig)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: soc_trig=%0b expected %0b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare after posedge
    task automatic step(input string tag, input logic e, input logic w);
        logic exp;
        @(negedge clk);
        raw_evt = e;
        cmp_wr  = w;
        exp = !w && e && (mcnt >= int'(div_sel));
        if (w) mcnt = 0;
        else if (e) mcnt = (mcnt >= int'(div_sel)) ? 0 : mcnt + 1;
        @(posedge clk);
        #1;
        chk(tag, soc_trig, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        raw_evt = 1'b0;
        cmp_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mcnt = 0;
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: run did not complete expected=done");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none

        do_reset();
        #1;
        chk("R1 reset", soc_trig, 1'b0);

        // R2 / R4 / R3: dense events over every ratio
        for (int r = 0; r < 16; r++) begin
            step("R2 idle", 1'b0, 1'b1);
            div_sel = 4'(r);
            for (int k = 0; k < 2 * (r + 1) + 3; k++) step(r == 0 ? "R4" : "R2", 1'b1, 1'b0);
        end

        // R9 / R3: sparse events, quiet cycles between
        for (int r = 0; r < 16; r++) begin
            step("R9 idle", 1'b0, 1'b1);
            div_sel = 4'(r);
            for (int k = 0; k < 3 * (r + 2); k++) step(k % 3 == 0 ? "R3" : "R9", k % 3 == 0, 1'b0);
        end

        // R5: strobe partway through a count
        for (int r = 1; r < 16; r++) begin
            step("R5 pre", 1'b0, 1'b1);
            div_sel = 4'(r);
            for (int k = 0; k < r / 2 + 1; k++) step("R5", 1'b1, 1'b0);
            step("R5 clear", 1'b0, 1'b1);
            for (int k = 0; k < r + 2; k++) step("R5", 1'b1, 1'b0);
        end

        // R6: strobe coincides with the matching event
        for (int r = 0; r < 6; r++) begin
            step("R6 pre", 1'b0, 1'b1);
            div_sel = 4'(r);
            for (int k = 0; k < r; k++) step("R6", 1'b1, 1'b0);
            step("R6 collide", 1'b1, 1'b1);
            for (int k = 0; k < r + 1; k++) step("R6 after", 1'b1, 1'b0);
        end

        // R7: raise the ratio mid-count, count kept
        step("R7 pre", 1'b0, 1'b1);
        div_sel = 4'd10;
        for (int k = 0; k < 4; k++) step("R7", 1'b1, 1'b0);
        div_sel = 4'd7;
        for (int k = 0; k < 6; k++) step("R7", 1'b1, 1'b0);
        div_sel = 4'd12;
        for (int k = 0; k < 3; k++) step("R7", 1'b1, 1'b0);
        div_sel = 4'd4;
        for (int k = 0; k < 8; k++) step("R7", 1'b1, 1'b0);

        // R8: lower the ratio below the current count
        step("R8 pre", 1'b0, 1'b1);
        div_sel = 4'd9;
        for (int k = 0; k < 6; k++) step("R8", 1'b1, 1'b0);
        div_sel = 4'd2;
        step("R8 quiet", 1'b0, 1'b0);
        step("R8 wrap", 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) step("R8", 1'b1, 1'b0);

        // R1: reset mid-count restarts the phase
        div_sel = 4'd5;
        step("R1 pre", 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) step("R1", 1'b1, 1'b0);
        do_reset();
        #1;
        chk("R1 after reset", soc_trig, 1'b0);
        for (int k = 0; k < 13; k++) step("R1", 1'b1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule